// File: doc/BRIEF.md
# Random Bit Collection Register Block

This peripheral gathers single entropy bits into an eight-word output buffer on request from software. It sits on a simple 32-bit register bus with a write strobe and combinational read data. Software programs a sample divider and sets the generator-enable bit. It then writes the number of bits it wants into the fill register and polls that register until it reads zero. The collected words are then read from a fixed window of eight word addresses.

The entropy source is one input bit. A slow sample tick, derived from the bus clock by the programmable divider, decides when a bit is taken. Each bit taken lowers the outstanding count by one, and the bits are packed least-significant first into consecutive words. A post-processing register is kept for software; writing zero to it selects raw output, and it does not alter the collected bits.

Top module: `trng_fill_ctrl`

## Requirements
- R1: After reset every mapped register (offsets 0x00, 0x20, 0x30, 0x50, 0x80 to 0x9c) reads zero.
- R2: Offset 0x00 holds the 15-bit divide field from write data bits [15:1]. It reads back in bits [15:1] with bit 0 and bits [31:16] reading zero.
- R3: While a fill is pending, one bit is sampled every 2*D clock cycles, where D is the divide field (a field of 0 acts as 1). The first bit is sampled 2*D cycles after the edge that starts counting, which is the fill write or the enable write.
- R4: Bit 31 of offset 0x20 enables sampling and reads back in bit 31. While it is clear, no bit is sampled, the outstanding count holds and the buffer words keep their values.
- R5: Offset 0x30 stores and reads back all 32 bits written to it. Its value does not alter the collected bits.
- R6: Writing N to offset 0x50 starts a fill. The register reads the outstanding count, which falls by one per sampled bit and reads zero when the fill is done.
- R7: A fill request above 256 is clamped to 256.
- R8: Sampled bit k of a fill (k from 0) lands in word k/32 at bit position k%32. Word j is read at offset 0x80+4*j. Bits beyond the request keep their earlier values.
- R9: A write to offset 0x50 while a fill is pending restarts at word 0, bit 0, with the new count and a fresh divider phase. Bits already stored stay until overwritten.
- R10: Reads of any other offset, including unaligned ones, return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| entropy_bit | input | 1 | Random bit source |

## Verification
The assertions assume that a write strobe lasts exactly one cycle and that the divide field is not changed while a fill is pending. The stimulus writes the divider only between fills, with every fill awaited by polling to zero. Only at the deliberate restart does it write the fill register mid-request. The entropy input comes from a 16-bit LFSR stepped on the falling clock edge, so the bit is steady at every rising edge. The bench records it cycle by cycle to predict the contents of every word.

// File: rtl/trng_fill_ctrl.sv
module trng_fill_ctrl #(
  parameter int AW     = 8,
  parameter int WORDS  = 8,
  parameter int DIVW   = 15,
  parameter int OFS_DIV  = 'h00,
  parameter int OFS_CTRL = 'h20,
  parameter int OFS_POST = 'h30,
  parameter int OFS_FILL = 'h50,
  parameter int OFS_BUF  = 'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          entropy_bit
);
  localparam int MAXB = WORDS * 32;
  localparam int CW   = $clog2(MAXB + 1);
  localparam int PW   = $clog2(MAXB);
  localparam int IW   = $clog2(WORDS);

  logic [DIVW-1:0] div_q;
  logic            en_q;
  logic [31:0]     post_q;
  logic [CW-1:0]   rem_q;
  logic [PW-1:0]   ptr_q;
  logic [DIVW:0]   cnt_q;
  logic [31:0]     buf_q [WORDS];

  wire [DIVW-1:0] div_eff   = (div_q == '0) ? DIVW'(1) : div_q;
  wire [DIVW:0]   period_m1 = {div_eff, 1'b0} - 1'b1;
  wire            busy      = (rem_q != '0);
  wire            tick      = en_q && busy && (cnt_q == period_m1);

  wire wr_div  = bus_wr && (bus_addr == AW'(OFS_DIV));
  wire wr_ctrl = bus_wr && (bus_addr == AW'(OFS_CTRL));
  wire wr_post = bus_wr && (bus_addr == AW'(OFS_POST));
  wire wr_fill = bus_wr && (bus_addr == AW'(OFS_FILL));

  wire [CW-1:0] fill_req = (bus_wdata > 32'(MAXB)) ? CW'(MAXB) : bus_wdata[CW-1:0];

  wire          buf_hit = (bus_addr[1:0] == 2'b00) && (bus_addr >= AW'(OFS_BUF)) &&
                          ({1'b0, bus_addr} < (AW+1)'(OFS_BUF + 4 * WORDS));
  wire [AW-1:0] buf_off = bus_addr - AW'(OFS_BUF);
  wire [IW-1:0] buf_idx = buf_off[IW+1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      en_q   <= 1'b0;
      post_q <= '0;
    end else begin
      if (wr_div)  div_q  <= bus_wdata[DIVW:1];
      if (wr_ctrl) en_q   <= bus_wdata[31];
      if (wr_post) post_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (wr_fill) begin
      rem_q <= fill_req;
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (!en_q || !busy || tick) begin
      cnt_q <= '0;
      if (tick) begin
        rem_q <= rem_q - 1'b1;
        ptr_q <= ptr_q + 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        buf_q[w] <= '0;
      else if (tick && !wr_fill && (ptr_q[PW-1:5] == IW'(w)))
        buf_q[w][ptr_q[4:0]] <= entropy_bit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_DIV))       bus_rdata = 32'(div_q) << 1;
    else if (bus_addr == AW'(OFS_CTRL)) bus_rdata = {en_q, 31'b0};
    else if (bus_addr == AW'(OFS_POST)) bus_rdata = post_q;
    else if (bus_addr == AW'(OFS_FILL)) bus_rdata = 32'(rem_q);
    else if (buf_hit)                   bus_rdata = buf_q[buf_idx];
  end
endmodule

// File: rtl/trng_fill_ctrl_chk.sv
module trng_fill_ctrl_chk #(
  parameter int AW = 8,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          en_q,
  input logic [CW-1:0] rem_q
);
  wire fill_wr  = bus_wr && (bus_addr == AW'('h50));
  wire in_buf   = (bus_addr >= AW'('h80)) && (bus_addr <= AW'('h9c)) && (bus_addr[1:0] == 2'b00);
  wire unmapped = !in_buf && (bus_addr != AW'('h00)) && (bus_addr != AW'('h20)) &&
                  (bus_addr != AW'('h30)) && (bus_addr != AW'('h50));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= CW'(256));

  a_r7_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_wr && bus_wdata > 32'd256) |=> (bus_rdata == 32'd256 || bus_addr != AW'('h50)) && rem_q == CW'(256));

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_wr && rem_q != '0) |=> (rem_q == $past(rem_q) || rem_q == $past(rem_q) - 1'b1));

  a_r6_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_wr && rem_q == '0) |=> rem_q == '0);

  a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !fill_wr) |=> $stable(rem_q));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> bus_rdata == 32'd0);
endmodule

bind trng_fill_ctrl trng_fill_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_q(en_q), .rem_q(rem_q)
);

// File: tb/trng_fill_ctrl_bench.sv
module trng_fill_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        entropy_bit;

  trng_fill_ctrl u_trng_fill_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entropy_bit(entropy_bit)
  );

  always #2 clk = ~clk;

  logic [15:0] lfsr = 16'hACE1;
  assign entropy_bit = lfsr[0];
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  int   cyc = 0;
  logic hist [200000];
  always @(posedge clk) begin
    hist[cyc] = entropy_bit;
    cyc = cyc + 1;
  end

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8];
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, output int edge_idx);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    edge_idx = cyc;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic poll(string req);
    logic [31:0] v;
    int n = 0;
    rd(8'h50, v);
    while (v != 0 && n < 20000) begin
      rd(8'h50, v);
      n++;
    end
    chk(req, v, 32'd0);
  endtask

  function automatic int period(int d);
    return 2 * ((d == 0) ? 1 : d);
  endfunction

  function automatic void apply_fill(int start, int p, int nbits);
    for (int k = 0; k < nbits; k++)
      model[k / 32][k % 32] = hist[start + (k + 1) * p];
  endfunction

  task automatic cmp_all(string req);
    logic [31:0] v;
    for (int j = 0; j < 8; j++) begin
      rd(8'(8'h80 + 4 * j), v);
      chk(req, v, model[j]);
    end
  endtask

  task automatic set_div(int d);
    int e;
    wr(8'h00, 32'(d) << 1, e);
  endtask

  initial begin
    int e, e2, d, n, nclamp;
    logic [31:0] v, pv;
    void'($urandom(32'h5eed1234));
    for (int j = 0; j < 8; j++) model[j] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1", v, 0);
    rd(8'h20, v); chk("R1", v, 0);
    rd(8'h30, v); chk("R1", v, 0);
    rd(8'h50, v); chk("R1", v, 0);
    rd(8'h80, v); chk("R1", v, 0);
    rd(8'h9c, v); chk("R1", v, 0);

    // R2 divider field readback
    wr(8'h00, 32'h0000_0007, e); rd(8'h00, v); chk("R2", v, 32'h6);
    wr(8'h00, 32'hFFFF_FFFF, e); rd(8'h00, v); chk("R2", v, 32'hFFFE);

    // R5 post register
    pv = $urandom;
    wr(8'h30, pv, e); rd(8'h30, v); chk("R5", v, pv);

    // R4 enable readback, R6/R8/R3 full fill
    set_div(1);
    wr(8'h20, 32'h8000_0000, e); rd(8'h20, v); chk("R4", v, 32'h8000_0000);
    wr(8'h50, 256, e);
    poll("R6");
    apply_fill(e, period(1), 256);
    cmp_all("R8");

    // R3/R6/R7/R8 random fills, post-processing toggled (R5)
    for (int t = 0; t < 10; t++) begin
      d = $urandom_range(0, 3);
      n = $urandom_range(1, 300);
      set_div(d);
      wr(8'h30, (t % 2 == 0) ? 32'h0 : $urandom, e);
      wr(8'h50, 32'(n), e);
      poll("R6");
      apply_fill(e, period(d), (n > 256) ? 256 : n);
      cmp_all("R3");
    end

    // R7 clamp of an oversized request
    set_div(2);
    wr(8'h50, 32'd1000, e);
    rd(8'h50, v); chk("R7", v, 32'd256);
    poll("R7");
    apply_fill(e, period(2), 256);
    cmp_all("R7");

    // R9 restart during a fill
    set_div(3);
    wr(8'h50, 32'd100, e);
    repeat (40) @(posedge clk);
    wr(8'h50, 32'd20, e2);
    rd(8'h50, v); chk("R9", v, 32'd20);
    nclamp = (e2 - e - 1) / period(3);
    if (nclamp > 100) nclamp = 100;
    apply_fill(e, period(3), nclamp);
    poll("R9");
    apply_fill(e2, period(3), 20);
    cmp_all("R9");

    // R4 disabled: count and words hold
    set_div(1);
    wr(8'h20, 32'h0, e);
    wr(8'h50, 32'd64, e);
    repeat (50) @(posedge clk);
    rd(8'h50, v); chk("R4", v, 32'd64);
    rd(8'h80, v); chk("R4", v, model[0]);
    wr(8'h20, 32'h8000_0000, e);
    poll("R4");
    apply_fill(e, period(1), 64);
    cmp_all("R4");

    // R10 unmapped offsets
    wr(8'h60, 32'hDEAD_BEEF, e);
    wr(8'h24, 32'h1234_5678, e);
    wr(8'h81, 32'hFFFF_FFFF, e);
    rd(8'h60, v); chk("R10", v, 0);
    rd(8'h24, v); chk("R10", v, 0);
    rd(8'h81, v); chk("R10", v, 0);
    rd(8'ha0, v); chk("R10", v, 0);
    rd(8'h00, v); chk("R10", v, 32'h2);
    rd(8'h20, v); chk("R10", v, 32'h8000_0000);
    rd(8'h50, v); chk("R10", v, 0);
    cmp_all("R10");

    done = 1;
  end

  initial begin
    int w = 0;
    while (!done && w < 190000) begin
      @(posedge clk);
      w++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule